// File: doc/BRIEF.md
# Cipher Unit Error Monitor

This block sits beside a block-cipher execution unit and watches the traffic around it: register writes and reads on a small address map, the busy flag of the cipher core, the flags of the input and output FIFOs, the done pulse and an internal-fault line from the core. Each kind of misuse it can recognise has its own sticky status bit. An interrupt-mask register can suppress any error, and the interrupt line is raised while at least one unsuppressed status bit is set.

The block also sequences the go register. Software pushes the last message block and then writes the go address. The last block is always 128 bits wide, and the data size register says how many of those bits are valid. A go write while the core is idle becomes a one-cycle start pulse. A go write while the core is busy is dropped and counts as a context error.

The register map uses a 4-bit address. The key occupies words 0 to 3, key size is 4, data size 5, mode 6, the IV words 7 and 8, go 9, the interrupt mask 10 and status-clear 11. Addresses 12 to 15 do not exist. The status bit order is: 0 address, 1 mode, 2 data size, 3 key size, 4 context, 5 early IV read, 6 input overflow, 7 output underflow, 8 output residue, 9 input residue, 10 internal. Reset is asynchronous and active low, and it is released through a two-flop synchronizer.

Top module: `cipher_err_mon`

## Requirements
- R1: A key-size write (address 4) with a value other than 16, 24 or 32 sets status bit 3.
- R2: A write to any key word, key size, data size, mode or IV address, or a go write (address 9), while busy is high sets status bit 4.
- R3: A read of an IV address (7 or 8) while busy is high sets status bit 5. Reads of other addresses and idle IV reads set nothing.
- R4: A data-size write (address 5) while the output FIFO is not empty sets status bit 8. A data-size value of 0 or above 128 sets status bit 2.
- R5: A done pulse while the input FIFO is not empty sets status bit 9.
- R6: A push while the input FIFO is full sets bit 6, and a pop while the output FIFO is empty sets bit 7.
- R7: A read or write to address 12 to 15 sets bit 0. A mode write (address 6) with any bit above bit 3 set sets bit 1.
- R8: The core fault input sets status bit 10.
- R9: Status bits are one cycle after the event and stay set until a write to address 11 carries a 1 in that bit position. When a set and a clear of the same bit coincide, the set wins.
- R10: Writing address 10 loads the mask from the low 11 data bits. A mask bit of 1 suppresses that error for the interrupt and a 0 lets it through. The mask resets to all zero.
- R11: The interrupt is high whenever any status bit is set whose mask bit is 0.
- R12: A go write while busy is low gives start high for exactly the next cycle. A go write while busy is high gives no start.
- R13: After reset, status, interrupt and start are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| core_busy | input | 1 | Cipher core is processing |
| core_fault | input | 1 | Internal fault from the core |
| core_done | input | 1 | Done pulse from the core |
| ififo_push | input | 1 | Input FIFO push |
| ififo_full | input | 1 | Input FIFO full |
| ififo_empty | input | 1 | Input FIFO empty |
| ofifo_pop | input | 1 | Output FIFO pop |
| ofifo_empty | input | 1 | Output FIFO empty |
| err_status | output | 11 | Sticky error status |
| err_irq | output | 1 | Interrupt, any unmasked error |
| core_start | output | 1 | One-cycle start pulse |

## Verification
Each error kind is first driven with its triggering pattern and then with the nearest pattern that must stay silent. The silent patterns are legal key sizes, an idle IV read, a busy read of a key word, a push into a FIFO that is not full, and a data-size write with the output FIFO empty. Together these show that each detector looks at the right address and the right flag. Masking, clearing and the set-beats-clear case separate the status store from the interrupt path. Go writes with busy low and with busy high separate the start pulse from the context error.

// File: rtl/cem_pkg.sv
package cem_pkg;
  localparam int NERR = 11;

  localparam int E_ADDR = 0;
  localparam int E_MODE = 1;
  localparam int E_DSZ  = 2;
  localparam int E_KSZ  = 3;
  localparam int E_CTX  = 4;
  localparam int E_ERD  = 5;
  localparam int E_IOVF = 6;
  localparam int E_OUNF = 7;
  localparam int E_ORES = 8;
  localparam int E_IRES = 9;
  localparam int E_INT  = 10;

  localparam int A_KEY_LO = 0;
  localparam int A_KEY_HI = 3;
  localparam int A_KSZ    = 4;
  localparam int A_DSZ    = 5;
  localparam int A_MODE   = 6;
  localparam int A_IV_LO  = 7;
  localparam int A_IV_HI  = 8;
  localparam int A_GO     = 9;
  localparam int A_MASK   = 10;
  localparam int A_CLR    = 11;
  localparam int A_LAST   = 11;

  typedef struct packed {
    logic ctx_w;
    logic ksz_w;
    logic dsz_w;
    logic mode_w;
    logic go_w;
    logic mask_w;
    logic clr_w;
    logic iv_r;
    logic bad;
  } acc_t;
endpackage

// File: rtl/cem_decode.sv
module cem_decode
  import cem_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);
  int unsigned a;

  always_comb begin
    a          = int'(addr);
    acc        = '0;
    acc.ksz_w  = wr && (a == A_KSZ);
    acc.dsz_w  = wr && (a == A_DSZ);
    acc.mode_w = wr && (a == A_MODE);
    acc.go_w   = wr && (a == A_GO);
    acc.mask_w = wr && (a == A_MASK);
    acc.clr_w  = wr && (a == A_CLR);
    acc.ctx_w  = wr && (a <= A_IV_HI);
    acc.iv_r   = rd && (a >= A_IV_LO) && (a <= A_IV_HI);
    acc.bad    = (wr || rd) && (a > A_LAST);
  end
endmodule

// File: rtl/cem_detect.sv
module cem_detect
  import cem_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BLK_BITS  = 128,
  parameter int MODE_BITS = 4
) (
  input  acc_t              acc,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              fault,
  input  logic              done,
  input  logic              in_push,
  input  logic              in_full,
  input  logic              in_empty,
  input  logic              out_pop,
  input  logic              out_empty,
  output logic [NERR-1:0]   ev
);
  localparam logic [DATA_W-1:0] KS16 = DATA_W'(16);
  localparam logic [DATA_W-1:0] KS24 = DATA_W'(24);
  localparam logic [DATA_W-1:0] KS32 = DATA_W'(32);
  localparam logic [DATA_W-1:0] DMAX = DATA_W'(BLK_BITS);

  logic ks_ok, ds_ok, mode_rsv;

  always_comb begin
    ks_ok    = (wdata == KS16) || (wdata == KS24) || (wdata == KS32);
    ds_ok    = (wdata != '0) && (wdata <= DMAX);
    mode_rsv = |(wdata >> MODE_BITS);
    ev         = '0;
    ev[E_ADDR] = acc.bad;
    ev[E_MODE] = acc.mode_w && mode_rsv;
    ev[E_DSZ]  = acc.dsz_w && !ds_ok;
    ev[E_KSZ]  = acc.ksz_w && !ks_ok;
    ev[E_CTX]  = busy && (acc.ctx_w || acc.go_w);
    ev[E_ERD]  = busy && acc.iv_r;
    ev[E_IOVF] = in_push && in_full;
    ev[E_OUNF] = out_pop && out_empty;
    ev[E_ORES] = acc.dsz_w && !out_empty;
    ev[E_IRES] = done && !in_empty;
    ev[E_INT]  = fault;
  end
endmodule

// File: rtl/cem_sticky.sv
module cem_sticky
  import cem_pkg::*;
(
  input  logic            clk,
  input  logic            rst_q,
  input  logic [NERR-1:0] ev,
  input  logic            clr_w,
  input  logic            mask_w,
  input  logic [NERR-1:0] wbits,
  output logic [NERR-1:0] status,
  output logic            irq
);
  logic [NERR-1:0] mask_q, mask_d, stat_d;

  for (genvar i = 0; i < NERR; i++) begin : g_bit
    always_comb begin
      stat_d[i] = ev[i] || (status[i] && !(clr_w && wbits[i]));
    end

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (status[i] && !(clr_w && wbits[i])) |=> status[i]);
  end

  always_comb begin
    mask_d = mask_w ? wbits : mask_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      status <= '0;
      mask_q <= '0;
    end else begin
      status <= stat_d;
      if (mask_w) mask_q <= mask_d;
    end
  end

  assign irq = |(status & ~mask_q);

  // R11
  irq_path_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!mask_w && (|(ev & ~mask_q))) |=> irq);
endmodule

// File: rtl/cipher_err_mon.sv
module cipher_err_mon
  import cem_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int BLK_BITS  = 128,
  parameter int MODE_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              core_busy,
  input  logic              core_fault,
  input  logic              core_done,
  input  logic              ififo_push,
  input  logic              ififo_full,
  input  logic              ififo_empty,
  input  logic              ofifo_pop,
  input  logic              ofifo_empty,
  output logic [NERR-1:0]   err_status,
  output logic              err_irq,
  output logic              core_start
);
  logic rs1, rst_q;
  acc_t acc;
  logic [NERR-1:0] ev;
  logic start_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1   <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rs1   <= 1'b1;
      rst_q <= rs1;
    end
  end

  cem_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr(reg_wr), .rd(reg_rd), .addr(reg_addr), .acc(acc)
  );

  cem_detect #(.DATA_W(DATA_W), .BLK_BITS(BLK_BITS), .MODE_BITS(MODE_BITS)) u_det (
    .acc(acc), .wdata(reg_wdata), .busy(core_busy), .fault(core_fault),
    .done(core_done), .in_push(ififo_push), .in_full(ififo_full),
    .in_empty(ififo_empty), .out_pop(ofifo_pop), .out_empty(ofifo_empty),
    .ev(ev)
  );

  cem_sticky u_stk (
    .clk(clk), .rst_q(rst_q), .ev(ev), .clr_w(acc.clr_w),
    .mask_w(acc.mask_w), .wbits(reg_wdata[NERR-1:0]),
    .status(err_status), .irq(err_irq)
  );

  always_comb begin
    start_d = acc.go_w && !core_busy;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) core_start <= 1'b0;
    else        core_start <= start_d;
  end

  // R12
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q)
    core_start |=> !core_start);
  // R12
  busy_go_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (reg_wr && (int'(reg_addr) == A_GO) && core_busy) |=> (!core_start && err_status[E_CTX]));
  // R6
  ovf_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (ififo_push && ififo_full) |=> err_status[E_IOVF]);
  // R1
  ksz_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (reg_wr && (int'(reg_addr) == A_KSZ) && (reg_wdata == DATA_W'(20))) |=> err_status[E_KSZ]);
endmodule

// File: tb/cipher_err_mon_bench.sv
module cipher_err_mon_bench;
  localparam int CLK_P = 10;
  localparam int NE = 11;

  logic clk = 0, rst_n = 0;
  logic wr, rd, busy, fault, done, push, full, iempty, pop, oempty;
  logic [3:0] addr;
  logic [31:0] wdata;
  logic [NE-1:0] status;
  logic irq, start;

  typedef struct {
    logic [NE-1:0] st;
    logic          irq;
    logic          start;
    string         tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  logic [NE-1:0] m_st = '0, m_mask = '0;

  always #(CLK_P/2) clk = ~clk;

  cipher_err_mon u_cipher_err_mon (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
    .reg_wdata(wdata), .core_busy(busy), .core_fault(fault), .core_done(done),
    .ififo_push(push), .ififo_full(full), .ififo_empty(iempty),
    .ofifo_pop(pop), .ofifo_empty(oempty), .err_status(status),
    .err_irq(irq), .core_start(start)
  );

  task automatic idle_inputs();
    wr = 0; rd = 0; addr = 0; wdata = 0; busy = 0; fault = 0; done = 0;
    push = 0; full = 0; iempty = 1; pop = 0; oempty = 1;
  endtask

  // caller sets inputs at a negedge; setb = bits the requirement says get set
  task automatic cyc(input string tag, input logic [NE-1:0] setb, input logic st);
    exp_t e;
    if (wr && addr == 4'd11) m_st = m_st & ~wdata[NE-1:0];
    m_st = m_st | setb;
    if (wr && addr == 4'd10) m_mask = wdata[NE-1:0];
    e.st = m_st; e.irq = |(m_st & ~m_mask); e.start = st; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d, input logic b,
                      input string tag, input logic [NE-1:0] setb, input logic st);
    wr = 1; addr = a; wdata = d; busy = b;
    cyc(tag, setb, st);
  endtask

  function automatic logic [NE-1:0] bit1(input int i);
    return NE'(1) << i;
  endfunction

  // monitor: compare one expectation per cycle, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (status !== e.st || irq !== e.irq || start !== e.start) begin
        errors++;
        $display("FAIL %s: status=%h irq=%b start=%b expected status=%h irq=%b start=%b",
                 e.tag, status, irq, start, e.st, e.irq, e.start);
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle_inputs();
    #(CLK_P*2 + 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    checks++;
    if (status !== '0 || irq !== 0 || start !== 0) begin
      errors++;
      $display("FAIL R13: status=%h irq=%b start=%b expected 0 0 0", status, irq, start);
    end

    wreg(4'd4, 32'd16, 0, "R1 ks16", '0, 0);
    wreg(4'd4, 32'd24, 0, "R1 ks24", '0, 0);
    wreg(4'd4, 32'd32, 0, "R1 ks32", '0, 0);
    wreg(4'd4, 32'd20, 0, "R1 ks20", bit1(3), 0);
    cyc("R9 hold", '0, 0);
    wreg(4'd11, 32'h8, 0, "R9 clear", '0, 0);
    cyc("R9 cleared", '0, 0);
    // set and clear together: set wins
    fault = 1; wr = 1; addr = 4'd11; wdata = 32'h400;
    cyc("R9 set wins R8", bit1(10), 0);
    wreg(4'd11, 32'h7FF, 0, "R9 clear all", '0, 0);

    wreg(4'd6, 32'h3, 1, "R2 mode busy", bit1(4), 0);
    wreg(4'd8, 32'h1, 1, "R2 iv busy", bit1(4), 0);
    wreg(4'd11, 32'h7FF, 0, "R2 clr", '0, 0);

    rd = 1; addr = 4'd7; busy = 1; cyc("R3 iv rd busy", bit1(5), 0);
    rd = 1; addr = 4'd7; cyc("R3 iv rd idle", '0, 0);
    rd = 1; addr = 4'd1; busy = 1; cyc("R3 key rd busy", '0, 0);

    wreg(4'd5, 32'd128, 0, "R4 dsz ok", '0, 0);
    oempty = 0; wreg(4'd5, 32'd64, 0, "R4 dsz ofifo", bit1(8), 0);
    wreg(4'd5, 32'd200, 0, "R4 dsz big", bit1(2), 0);
    wreg(4'd11, 32'h7FF, 0, "R4 clr", '0, 0);
    wreg(4'd5, 32'd0, 0, "R4 dsz zero", bit1(2), 0);

    done = 1; cyc("R5 done empty", '0, 0);
    done = 1; iempty = 0; cyc("R5 done residue", bit1(9), 0);

    push = 1; cyc("R6 push ok", '0, 0);
    push = 1; full = 1; cyc("R6 overflow", bit1(6), 0);
    pop = 1; oempty = 0; cyc("R6 pop ok", '0, 0);
    pop = 1; cyc("R6 underflow", bit1(7), 0);
    wreg(4'd11, 32'h7FF, 0, "R6 clr", '0, 0);

    wreg(4'd14, 32'd0, 0, "R7 bad wr", bit1(0), 0);
    wreg(4'd11, 32'h1, 0, "R7 clr", '0, 0);
    rd = 1; addr = 4'd15; cyc("R7 bad rd", bit1(0), 0);
    wreg(4'd6, 32'hF, 0, "R7 mode ok", '0, 0);
    wreg(4'd6, 32'h80, 0, "R7 mode rsv", bit1(1), 0);
    wreg(4'd11, 32'h7FF, 0, "R7 clr all", '0, 0);

    wreg(4'd10, 32'h7FF, 0, "R10 mask all", '0, 0);
    fault = 1; cyc("R10 masked R8", bit1(10), 0);
    wreg(4'd10, 32'h3FF, 0, "R11 unmask int", '0, 0);
    wreg(4'd10, 32'h000, 0, "R10 mask clear", '0, 0);
    wreg(4'd11, 32'h7FF, 0, "R11 clr", '0, 0);

    wreg(4'd9, 32'd0, 0, "R12 go idle", '0, 1);
    cyc("R12 pulse ends", '0, 0);
    wreg(4'd9, 32'd0, 1, "R12 go busy", bit1(4), 0);

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule